// File: doc/BRIEF.md
# BCD Time-of-Day Keeper with Hourly Chime and Night Lamp

This block holds a 24-hour time of day as six BCD digits (hours, minutes, seconds, each a tens and a units digit). A single-cycle enable, pulsed once per second by an upstream divider, advances the time. Two active-low push buttons step the hour field and the minute field by hand. The buttons are assumed to be debounced before they reach this block.

Two lamp outputs are derived from the time. The chime lamp blinks at the rate of a separate 1 Hz square-wave input. It starts five seconds before each full hour and stops when the hour turns over. The night lamp comes on at six in the evening and goes off at five in the morning, so its window wraps past midnight. Everything runs on one system clock with a synchronous, active-high reset. Reset loads a preset time rather than midnight.

Top module: `tod_keeper`

## Requirements
- R1: While reset is asserted and after it is released, the time reads 03:59:55 (digits 0,3,5,9,5,5), and both lamp latches are off.
- R2: Each cycle with `secTick` high advances the seconds by one. The units digit goes from 9 to 0 and increments the tens digit, and 59 wraps to 00. The digits update one clock after the tick cycle.
- R3: A seconds wrap from 59 to 00 advances the minutes by one. The minutes count 00 to 59 with the same BCD digit rules.
- R4: A minutes wrap that is caused by a seconds wrap advances the hours. The hours count 00 to 23 and wrap from 23 to 00.
- R5: A low `hourSetN` or `minSetN` advances its own field by exactly one step per `secTick`. A button held low with no tick leaves the time unchanged. The seconds keep counting during manual setting.
- R6: A manual minute step from 59 wraps the minutes to 00 and does not change the hours, unless the seconds wrap in that same tick.
- R7: The chime enable turns on one clock after minutes:seconds reads 59:55 and turns off one clock after it reads 00:00. `chimeLamp` equals the enable ANDed with `blinkIn`.
- R8: The night lamp turns on one clock after the time reads exactly 18:00:00 and off one clock after it reads exactly 05:00:00. Between those two events it holds its state, including across midnight.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous reset, active high |
| secTick | input | 1 | One-cycle pulse, once per second |
| hourSetN | input | 1 | Hour step button, active low, debounced |
| minSetN | input | 1 | Minute step button, active low, debounced |
| blinkIn | input | 1 | 1 Hz square wave, 50 % duty |
| hourTens | output | 4 | Hour tens digit, BCD |
| hourUnits | output | 4 | Hour units digit, BCD |
| minTens | output | 4 | Minute tens digit, BCD |
| minUnits | output | 4 | Minute units digit, BCD |
| secTens | output | 4 | Second tens digit, BCD |
| secUnits | output | 4 | Second units digit, BCD |
| chimeLamp | output | 1 | Hourly chime lamp |
| nightLamp | output | 1 | Overnight street lamp |

## Verification
Plain free-running ticks are used across seconds, minutes and hour rollovers. These separate the digit-level BCD carries from the cascade between fields. Runs with a button held combine manual steps with a seconds wrap in the same tick. This tells a single OR-ed advance apart from a double step, and a manual minute wrap apart from a natural carry into the hours. The hour button drives the time through 23 to 00. The lamps are checked on both sides of 59:55, 00:00, 18:00:00 and 05:00:00, with the blink input held at each level to separate the latch from the gating.

// File: rtl/tod_pkg.sv
package tod_pkg;
  localparam int DIGIT_W = 4;
  localparam int FIELD_W = 2 * DIGIT_W;
  localparam int TIME_W  = 3 * FIELD_W;

  typedef struct packed {
    logic [FIELD_W-1:0] hr;
    logic [FIELD_W-1:0] mn;
    logic [FIELD_W-1:0] sc;
  } todTime_t;

  typedef struct packed {
    logic secStep;
    logic minStep;
    logic hourStep;
  } stepStrobes_t;

  // Advance a two-digit BCD field, wrapping to zero after lastVal.
  function automatic logic [FIELD_W-1:0] bcdNext(input logic [FIELD_W-1:0] v,
                                                 input logic [FIELD_W-1:0] lastVal);
    logic [DIGIT_W-1:0] tens;
    logic [DIGIT_W-1:0] units;
    tens  = v[FIELD_W-1:DIGIT_W];
    units = v[DIGIT_W-1:0];
    if (v == lastVal)
      return '0;
    else if (units == DIGIT_W'(9))
      return {tens + DIGIT_W'(1), {DIGIT_W{1'b0}}};
    else
      return {tens, units + DIGIT_W'(1)};
  endfunction
endpackage

// File: rtl/tod_datapath.sv
module tod_datapath
  import tod_pkg::*;
#(
  parameter logic [TIME_W-1:0]  INIT_TIME = 24'h03_59_55,
  parameter logic [FIELD_W-1:0] SEC_LAST  = 8'h59,
  parameter logic [FIELD_W-1:0] MIN_LAST  = 8'h59,
  parameter logic [FIELD_W-1:0] HOUR_LAST = 8'h23
) (
  input  logic         clk,
  input  logic         rst,
  input  stepStrobes_t strobes,
  output todTime_t     timeNow
);
  todTime_t timeQ;

  always_ff @(posedge clk) begin
    if (rst) begin
      timeQ <= todTime_t'(INIT_TIME);
    end else begin
      if (strobes.secStep)  timeQ.sc <= bcdNext(timeQ.sc, SEC_LAST);
      if (strobes.minStep)  timeQ.mn <= bcdNext(timeQ.mn, MIN_LAST);
      if (strobes.hourStep) timeQ.hr <= bcdNext(timeQ.hr, HOUR_LAST);
    end
  end

  assign timeNow = timeQ;

  // R2
  sec_range_chk: assert property (@(posedge clk) disable iff (rst)
    timeQ.sc[DIGIT_W-1:0] <= DIGIT_W'(9) && timeQ.sc <= SEC_LAST);
  // R3
  min_range_chk: assert property (@(posedge clk) disable iff (rst)
    timeQ.mn[DIGIT_W-1:0] <= DIGIT_W'(9) && timeQ.mn <= MIN_LAST);
  // R4
  hour_range_chk: assert property (@(posedge clk) disable iff (rst)
    timeQ.hr[DIGIT_W-1:0] <= DIGIT_W'(9) && timeQ.hr <= HOUR_LAST);
  // R4
  hour_wrap_chk: assert property (@(posedge clk) disable iff (rst)
    (strobes.hourStep && timeQ.hr == HOUR_LAST) |=> timeQ.hr == '0);
endmodule

// File: rtl/tod_ctrl.sv
module tod_ctrl
  import tod_pkg::*;
#(
  parameter logic [FIELD_W-1:0] SEC_LAST    = 8'h59,
  parameter logic [FIELD_W-1:0] MIN_LAST    = 8'h59,
  parameter logic [2*FIELD_W-1:0] CHIME_ON  = 16'h59_55,
  parameter logic [TIME_W-1:0]  NIGHT_ON    = 24'h18_00_00,
  parameter logic [TIME_W-1:0]  NIGHT_OFF   = 24'h05_00_00
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         secTick,
  input  logic         hourSetN,
  input  logic         minSetN,
  input  logic         blinkIn,
  input  todTime_t     timeNow,
  output stepStrobes_t strobes,
  output logic         chimeLamp,
  output logic         nightLamp
);
  logic secWrap;
  logic minWrap;
  logic atChimeOn;
  logic atHourTop;
  logic chimeEn;
  logic nightOn;

  assign secWrap   = timeNow.sc == SEC_LAST;
  assign minWrap   = timeNow.mn == MIN_LAST;
  assign atChimeOn = {timeNow.mn, timeNow.sc} == CHIME_ON;
  assign atHourTop = {timeNow.mn, timeNow.sc} == '0;

  always_comb begin
    strobes.secStep  = secTick;
    strobes.minStep  = secTick && (!minSetN || secWrap);
    strobes.hourStep = secTick && (!hourSetN || (secWrap && minWrap));
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      chimeEn <= 1'b0;
      nightOn <= 1'b0;
    end else begin
      if (atChimeOn)      chimeEn <= 1'b1;
      else if (atHourTop) chimeEn <= 1'b0;
      if (timeNow == todTime_t'(NIGHT_ON))       nightOn <= 1'b1;
      else if (timeNow == todTime_t'(NIGHT_OFF)) nightOn <= 1'b0;
    end
  end

  assign chimeLamp = chimeEn && blinkIn;
  assign nightLamp = nightOn;

  // R5
  idle_hold_chk: assert property (@(posedge clk) disable iff (rst)
    !secTick |=> $stable(timeNow));
  // R6
  manual_min_nocarry_chk: assert property (@(posedge clk) disable iff (rst)
    (secTick && !minSetN && hourSetN && minWrap && !secWrap) |=> timeNow.hr == $past(timeNow.hr));
  // R7
  chime_start_chk: assert property (@(posedge clk) disable iff (rst)
    $rose(chimeEn) |-> $past(atChimeOn));
  // R7
  chime_stop_chk: assert property (@(posedge clk) disable iff (rst)
    $fell(chimeEn) |-> $past(atHourTop));
  // R8
  night_start_chk: assert property (@(posedge clk) disable iff (rst)
    $rose(nightOn) |-> $past(timeNow == todTime_t'(NIGHT_ON)));
  // R8
  night_stop_chk: assert property (@(posedge clk) disable iff (rst)
    $fell(nightOn) |-> $past(timeNow == todTime_t'(NIGHT_OFF)));
endmodule

// File: rtl/tod_keeper.sv
module tod_keeper
  import tod_pkg::*;
#(
  parameter logic [TIME_W-1:0]    INIT_TIME = 24'h03_59_55,
  parameter logic [2*FIELD_W-1:0] CHIME_ON  = 16'h59_55,
  parameter logic [TIME_W-1:0]    NIGHT_ON  = 24'h18_00_00,
  parameter logic [TIME_W-1:0]    NIGHT_OFF = 24'h05_00_00
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               secTick,
  input  logic               hourSetN,
  input  logic               minSetN,
  input  logic               blinkIn,
  output logic [DIGIT_W-1:0] hourTens,
  output logic [DIGIT_W-1:0] hourUnits,
  output logic [DIGIT_W-1:0] minTens,
  output logic [DIGIT_W-1:0] minUnits,
  output logic [DIGIT_W-1:0] secTens,
  output logic [DIGIT_W-1:0] secUnits,
  output logic               chimeLamp,
  output logic               nightLamp
);
  localparam logic [FIELD_W-1:0] SEC_LAST  = 8'h59;
  localparam logic [FIELD_W-1:0] MIN_LAST  = 8'h59;
  localparam logic [FIELD_W-1:0] HOUR_LAST = 8'h23;

  stepStrobes_t strobes;
  todTime_t     timeNow;

  tod_ctrl #(
    .SEC_LAST (SEC_LAST),
    .MIN_LAST (MIN_LAST),
    .CHIME_ON (CHIME_ON),
    .NIGHT_ON (NIGHT_ON),
    .NIGHT_OFF(NIGHT_OFF)
  ) ctrl_i (
    .clk      (clk),
    .rst      (rst),
    .secTick  (secTick),
    .hourSetN (hourSetN),
    .minSetN  (minSetN),
    .blinkIn  (blinkIn),
    .timeNow  (timeNow),
    .strobes  (strobes),
    .chimeLamp(chimeLamp),
    .nightLamp(nightLamp)
  );

  tod_datapath #(
    .INIT_TIME(INIT_TIME),
    .SEC_LAST (SEC_LAST),
    .MIN_LAST (MIN_LAST),
    .HOUR_LAST(HOUR_LAST)
  ) dp_i (
    .clk    (clk),
    .rst    (rst),
    .strobes(strobes),
    .timeNow(timeNow)
  );

  assign {hourTens, hourUnits} = timeNow.hr;
  assign {minTens,  minUnits}  = timeNow.mn;
  assign {secTens,  secUnits}  = timeNow.sc;
endmodule

// File: tb/tod_keeper_tb.sv
module tod_keeper_tb_top;
  localparam time CLK_PERIOD = 10ns;
  localparam int  NUM_VEC    = 17;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic secTick = 1'b0;
  logic hourSetN = 1'b1;
  logic minSetN = 1'b1;
  logic blinkIn = 1'b1;
  logic [3:0] hourTens, hourUnits, minTens, minUnits, secTens, secUnits;
  logic chimeLamp, nightLamp;

  int testsRun = 0;
  int testsFailed = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  tod_keeper dut_i (
    .clk(clk), .rst(rst), .secTick(secTick), .hourSetN(hourSetN), .minSetN(minSetN),
    .blinkIn(blinkIn), .hourTens(hourTens), .hourUnits(hourUnits), .minTens(minTens),
    .minUnits(minUnits), .secTens(secTens), .secUnits(secUnits),
    .chimeLamp(chimeLamp), .nightLamp(nightLamp)
  );

  // {ticks[7:0], hourSetN, minSetN, expected hhmmss BCD, chime, night}; blinkIn held high
  localparam logic [35:0] VEC [NUM_VEC] = '{
    {8'd1,  1'b1, 1'b1, 24'h03_59_56, 1'b1, 1'b0}, // R2, R7 on
    {8'd4,  1'b1, 1'b1, 24'h04_00_00, 1'b0, 1'b0}, // R3, R4, R7 off
    {8'd1,  1'b0, 1'b1, 24'h05_00_01, 1'b0, 1'b0}, // R5 hour
    {8'd1,  1'b1, 1'b0, 24'h05_01_02, 1'b0, 1'b0}, // R5 minute
    {8'd12, 1'b0, 1'b1, 24'h17_01_14, 1'b0, 1'b0}, // R5
    {8'd58, 1'b1, 1'b0, 24'h17_59_12, 1'b0, 1'b0}, // R5 with seconds wrap
    {8'd43, 1'b1, 1'b1, 24'h17_59_55, 1'b1, 1'b0}, // R7
    {8'd5,  1'b1, 1'b1, 24'h18_00_00, 1'b0, 1'b1}, // R4, R8 on
    {8'd1,  1'b1, 1'b1, 24'h18_00_01, 1'b0, 1'b1}, // R8 hold
    {8'd59, 1'b1, 1'b0, 24'h18_59_00, 1'b0, 1'b1}, // R5
    {8'd1,  1'b1, 1'b0, 24'h18_00_01, 1'b0, 1'b1}, // R6
    {8'd5,  1'b0, 1'b1, 24'h23_00_06, 1'b0, 1'b1}, // R5
    {8'd1,  1'b0, 1'b1, 24'h00_00_07, 1'b0, 1'b1}, // R4 wrap, R8 past midnight
    {8'd4,  1'b0, 1'b1, 24'h04_00_11, 1'b0, 1'b1}, // R8 hold
    {8'd59, 1'b1, 1'b0, 24'h04_59_10, 1'b0, 1'b1}, // R5
    {8'd45, 1'b1, 1'b1, 24'h04_59_55, 1'b1, 1'b1}, // R7
    {8'd5,  1'b1, 1'b1, 24'h05_00_00, 1'b0, 1'b0}  // R8 off
  };

  function automatic logic [23:0] readTime();
    return {hourTens, hourUnits, minTens, minUnits, secTens, secUnits};
  endfunction

  task automatic check(input bit ok, input string req, input logic [23:0] act, input logic [23:0] exp);
    testsRun++;
    if (!ok) begin
      testsFailed++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic tickOnce();
    @(negedge clk) secTick = 1'b1;
    @(negedge clk) secTick = 1'b0;
  endtask

  initial begin
    #(CLK_PERIOD * 150000);
    testsFailed++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("  [TB] %0d tests run, %0d failed", testsRun, testsFailed);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    // R1: held in reset
    check(readTime() == 24'h03_59_55, "R1 time in reset", readTime(), 24'h03_59_55);
    check(!chimeLamp && !nightLamp, "R1 lamps in reset", {22'd0, chimeLamp, nightLamp}, 24'd0);
    rst = 1'b0;
    @(negedge clk);
    // R7: 59:55 is read right after reset, enable latches on
    blinkIn = 1'b1;
    #1 check(chimeLamp == 1'b1, "R7 chime follows blink high", {23'd0, chimeLamp}, 24'd1);
    blinkIn = 1'b0;
    #1 check(chimeLamp == 1'b0, "R7 chime gated by blink low", {23'd0, chimeLamp}, 24'd0);
    blinkIn = 1'b1;
    check(nightLamp == 1'b0, "R1 night lamp off after reset", {23'd0, nightLamp}, 24'd0);
    // R5: buttons low without a tick change nothing
    hourSetN = 1'b0;
    minSetN = 1'b0;
    repeat (5) @(negedge clk);
    check(readTime() == 24'h03_59_55, "R5 held buttons without tick", readTime(), 24'h03_59_55);
    hourSetN = 1'b1;
    minSetN = 1'b1;

    for (int v = 0; v < NUM_VEC; v++) begin
      hourSetN = VEC[v][27];
      minSetN  = VEC[v][26];
      for (int t = 0; t < int'(VEC[v][35:28]); t++) tickOnce();
      hourSetN = 1'b1;
      minSetN  = 1'b1;
      @(negedge clk);
      check(readTime() == VEC[v][25:2], $sformatf("R2/R3/R4/R5/R6 vector %0d time", v),
            readTime(), VEC[v][25:2]);
      check(chimeLamp == VEC[v][1], $sformatf("R7 vector %0d chime", v),
            {23'd0, chimeLamp}, {23'd0, VEC[v][1]});
      check(nightLamp == VEC[v][0], $sformatf("R8 vector %0d night", v),
            {23'd0, nightLamp}, {23'd0, VEC[v][0]});
    end

    // R1: reset in mid-run restores the preset and clears the latches
    rst = 1'b1;
    repeat (2) @(negedge clk);
    check(readTime() == 24'h03_59_55, "R1 time after second reset", readTime(), 24'h03_59_55);
    check(!chimeLamp && !nightLamp, "R1 lamps after second reset", {22'd0, chimeLamp, nightLamp}, 24'd0);

    $display("  [TB] %0d tests run, %0d failed", testsRun, testsFailed);
    $finish;
  end
endmodule